// File: doc/BRIEF.md
# Serial-loaded phase accumulator synthesizer

This block is the numerically controlled oscillator core of a direct digital synthesizer. A host loads a 40-bit configuration word one bit at a time over two wires, a data line and a word clock. A separate update strobe then copies the finished word into the active configuration. On every system clock a 32-bit accumulator adds the tuning word, so the output frequency is tuning × f_clk / 2^32. A 5-bit phase offset is added to the accumulator's top bits. The block drives the truncated phase and a square wave taken from its MSB.

The word clock, data, update and clear inputs are asynchronous to the system clock. Each passes through a two-flop synchroniser, and edges are detected in the system-clock domain. After a clear the block is in parallel mode, which means it ignores serial traffic. It switches to serial loading only after one word-clock pulse followed by one update pulse. The parallel byte path, the sine lookup and the DAC sit outside this block.

Top module: `pacc_synth`

## Requirements
- R1: After rst_ni is asserted, or after clear_i has been held high, phase_o and sq_o are 0, ser_mode_o is 0 (parallel mode), and the shifted word, the active word and the accumulator are all zero.
- R2: In parallel mode, a word-clock rising edge followed later by an update rising edge sets ser_mode_o to 1. The flag then stays 1 until the next clear.
- R3: In parallel mode, an update pulse that no word-clock pulse preceded leaves ser_mode_o at 0. Word-clock pulses in parallel mode shift nothing, so they never reach the active word.
- R4: In serial mode, each word-clock rising edge captures sdata_i LSB first: the first bit sent ends up in bit 0. The word layout is: bits 31:0 tuning, bits 33:32 control, bit 34 power-down, bits 39:35 phase offset.
- R5: Shifting changes nothing at the outputs. The new word takes effect only on an update rising edge in serial mode.
- R6: While powered up, the accumulator grows by the tuning word modulo 2^32 on every system clock.
- R7: The phase output equals the accumulator plus the offset placed at bits 31:27, taken modulo 2^32 and then truncated to its top OUT_W bits.
- R8: sq_o equals the MSB of the offset phase.
- R9: While the power-down bit is set, the accumulator holds its value and phase_o and sq_o are 0. Clearing the bit resumes stepping from the held value.
- R10: Non-zero control bits have no effect; the tuning, power-down and phase fields still apply.
- R11: An update that rises at the input takes effect at the third system-clock edge. With a tuning word of T and an accumulator of zero, the accumulator equals n·T after n further edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Asynchronous level clear; returns the block to parallel mode |
| wclk_i | input | 1 | Serial word clock; captures data on its rising edge |
| sdata_i | input | 1 | Serial data, LSB first |
| upd_i | input | 1 | Update strobe; acts on its rising edge |
| phase_o | output | OUT_W | Truncated phase after the offset is added |
| sq_o | output | 1 | Square wave taken from the phase MSB |
| ser_mode_o | output | 1 | 1 when serial loading is enabled |

## Verification
The assertions check on every cycle that:
- the accumulator steps by exactly the active tuning word;
- the accumulator freezes and the outputs stay low under power-down;
- serial mode persists until a clear, and a clear always lands in parallel mode;
- the shift register is frozen in parallel mode;
- the active word changes only on an update edge.

Only the bench scenarios can show:
- the LSB-first bit order and the field layout;
- the exact three-edge update latency and the absolute phase with its offset;
- the discarding of words shifted in parallel mode;
- the arming order of the mode-entry sequence.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
  localparam int unsigned TW_W   = 32;
  localparam int unsigned CTL_W  = 2;
  localparam int unsigned PH_W   = 5;
  localparam int unsigned WORD_W = TW_W + CTL_W + 1 + PH_W;

  typedef struct packed {
    logic [PH_W-1:0]  phase;
    logic             pdn;
    logic [CTL_W-1:0] ctrl;
    logic [TW_W-1:0]  tw;
  } cfg_t;

  typedef enum logic {MODE_PAR = 1'b0, MODE_SER = 1'b1} mode_e;
endpackage

// File: rtl/pacc_sync.sv
module pacc_sync #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign lvl_o[g]  = s2_q;
    assign rise_o[g] = s2_q & ~s3_q;
  end
endmodule

// File: rtl/pacc_ctrl.sv
module pacc_ctrl
  import pacc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic wclk_rise_i,
  input  logic sdata_i,
  input  logic upd_rise_i,
  output cfg_t cfg_o,
  output logic ser_mode_o
);
  mode_e              mode_q;
  logic               armed_q;
  logic [WORD_W-1:0]  shreg_q;
  cfg_t               active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_PAR;
      armed_q  <= 1'b0;
      shreg_q  <= '0;
      active_q <= '0;
    end else if (clr_i) begin
      mode_q   <= MODE_PAR;
      armed_q  <= 1'b0;
      shreg_q  <= '0;
      active_q <= '0;
    end else if (mode_q == MODE_PAR) begin
      if (wclk_rise_i) armed_q <= 1'b1;
      if (upd_rise_i && armed_q) begin
        mode_q  <= MODE_SER;
        armed_q <= 1'b0;
      end
    end else begin
      if (wclk_rise_i) shreg_q <= {sdata_i, shreg_q[WORD_W-1:1]};
      if (upd_rise_i) active_q <= cfg_t'(shreg_q);
    end
  end

  assign cfg_o      = active_q;
  assign ser_mode_o = (mode_q == MODE_SER);

  AST_CLR_PAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (mode_q == MODE_PAR)); // R1
  AST_SER_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SER && !clr_i) |=> (mode_q == MODE_SER)); // R2
  AST_PAR_NO_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_PAR) |=> $stable(shreg_q)); // R3
  AST_ACTIVE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_rise_i && !clr_i) |=> $stable(active_q)); // R5
endmodule

// File: rtl/pacc_accum.sv
module pacc_accum #(
  parameter int unsigned ACC_W = 32,
  parameter int unsigned PH_W  = 5,
  parameter int unsigned OUT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [ACC_W-1:0] tw_i,
  input  logic [PH_W-1:0]  ph_i,
  input  logic             pdn_i,
  output logic [OUT_W-1:0] phase_o,
  output logic             sq_o
);
  localparam int unsigned PAD_W = ACC_W - PH_W;

  logic [ACC_W-1:0] acc_q, phase_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (!pdn_i) acc_q <= acc_q + tw_i;
  end

  assign phase_full = acc_q + {ph_i, {PAD_W{1'b0}}};
  assign phase_o    = pdn_i ? '0 : phase_full[ACC_W-1 -: OUT_W];
  assign sq_o       = pdn_i ? 1'b0 : phase_full[ACC_W-1];

  AST_PDN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pdn_i && !clr_i) |=> $stable(acc_q)); // R9
  AST_ACC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pdn_i && !clr_i) |=> (acc_q == $past(acc_q) + $past(tw_i))); // R6
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (acc_q == '0)); // R1
endmodule

// File: rtl/pacc_synth.sv
module pacc_synth
  import pacc_pkg::*;
#(
  parameter int unsigned OUT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             wclk_i,
  input  logic             sdata_i,
  input  logic             upd_i,
  output logic [OUT_W-1:0] phase_o,
  output logic             sq_o,
  output logic             ser_mode_o
);
  localparam int unsigned NSYNC = 4;

  logic [NSYNC-1:0] lvl, rise;
  cfg_t             cfg;

  pacc_sync #(.N(NSYNC)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({clear_i, upd_i, wclk_i, sdata_i}),
    .lvl_o  (lvl),
    .rise_o (rise)
  );

  pacc_ctrl i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (lvl[3]),
    .wclk_rise_i (rise[1]),
    .sdata_i     (lvl[0]),
    .upd_rise_i  (rise[2]),
    .cfg_o       (cfg),
    .ser_mode_o  (ser_mode_o)
  );

  pacc_accum #(.ACC_W(TW_W), .PH_W(PH_W), .OUT_W(OUT_W)) i_accum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (lvl[3]),
    .tw_i    (cfg.tw),
    .ph_i    (cfg.phase),
    .pdn_i   (cfg.pdn),
    .phase_o (phase_o),
    .sq_o    (sq_o)
  );

  AST_PDN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg.pdn |-> (phase_o == '0 && !sq_o)); // R9
endmodule

// File: tb/test_pacc_synth.sv
module test_pacc_synth;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear = 1'b0, wclk = 1'b0, sdata = 1'b0, upd = 1'b0;
  logic [31:0] phase;
  logic        sq, ser;
  int          n_chk = 0, n_bad = 0, cyc = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  pacc_synth #(.OUT_W(32)) i_pacc_synth (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .wclk_i(wclk),
    .sdata_i(sdata), .upd_i(upd), .phase_o(phase), .sq_o(sq), .ser_mode_o(ser)
  );

  function automatic logic [39:0] mk_word(logic [31:0] t, logic [1:0] c, logic p, logic [4:0] ph);
    return {ph, p, c, t};
  endfunction

  function automatic logic [31:0] exp_phase(int n, logic [31:0] t, logic [4:0] ph);
    logic [31:0] nn = 32'(n);
    return nn * t + {ph, 27'd0};
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1'b1; wait_n(4); clear = 1'b0; wait_n(4);
  endtask

  task automatic pulse_wclk();
    @(negedge clk); wclk = 1'b1; wait_n(3); wclk = 1'b0; wait_n(3);
  endtask

  task automatic pulse_upd();
    @(negedge clk); upd = 1'b1; wait_n(4); upd = 1'b0; wait_n(4);
  endtask

  task automatic shift_word(logic [39:0] w);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); sdata = w[i];
      pulse_wclk();
    end
  endtask

  // update rises at input, load on third posedge, then n more edges
  task automatic load_timed(logic [39:0] w, int n);
    shift_word(w);
    @(negedge clk); upd = 1'b1;
    repeat (3 + n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic step_check(logic [31:0] t, string req);
    logic [31:0] a, b;
    @(negedge clk); a = phase;
    @(negedge clk); b = phase;
    check((b - a) == t, req, 64'(b - a), 64'(t));
  endtask

  initial begin
    logic [31:0] t, t2;
    logic [4:0]  ph;
    logic [1:0]  c;
    logic [31:0] e;
    int          n;
    void'($urandom(32'd1234));
    wait_n(5);
    rst_n = 1'b1;
    @(negedge clk);
    check(phase == 0 && !sq, "R1 reset outputs", 64'(phase), 64'd0);
    check(!ser, "R1 reset mode", 64'(ser), 64'd0);

    // parallel mode: lone update, then shifted word discarded
    do_clear();
    pulse_upd();
    check(!ser, "R3 update without word clock", 64'(ser), 64'd0);
    do_clear();
    shift_word(mk_word(32'h1234_5678, 2'b00, 1'b0, 5'd3));
    check(!ser, "R3 shifted in parallel mode", 64'(ser), 64'd0);
    pulse_upd();
    check(ser, "R2 entry via word clock then update", 64'(ser), 64'd1);
    wait_n(10);
    check(phase == 0, "R3 parallel word not loaded", 64'(phase), 64'd0);

    // random loads with absolute timing
    for (int it = 0; it < 12; it++) begin
      do_clear();
      check(!ser && phase == 0, "R1 clear state", 64'({ser, phase}), 64'd0);
      pulse_wclk();
      pulse_upd();
      check(ser, "R2 mode entry", 64'(ser), 64'd1);
      t  = $urandom;
      ph = 5'($urandom);
      c  = 2'($urandom);
      n  = 3 + it;
      load_timed(mk_word(t, c, 1'b0, ph), n);
      e = exp_phase(n, t, ph);
      check(phase == e, "R4 R7 R11 absolute phase", 64'(phase), 64'(e));
      check(sq == e[31], "R8 square msb", 64'(sq), 64'(e[31]));
      upd = 1'b0;
      step_check(t, "R6 step");
    end

    // wrap and square toggling
    do_clear(); pulse_wclk(); pulse_upd();
    load_timed(mk_word(32'hFFFF_FFFF, 2'b00, 1'b0, 5'd0), 3);
    check(phase == 32'hFFFF_FFFD, "R6 wrap", 64'(phase), 64'hFFFF_FFFD);
    upd = 1'b0;
    do_clear(); pulse_wclk(); pulse_upd();
    load_timed(mk_word(32'h8000_0000, 2'b00, 1'b0, 5'd16), 1);
    check(sq == 1'b0, "R8 square with half-cycle offset", 64'(sq), 64'd0);
    @(negedge clk);
    check(sq == 1'b1, "R8 square toggles", 64'(sq), 64'd1);
    upd = 1'b0;

    // double buffering
    t  = 32'h0101_0101;
    t2 = 32'h0303_0000;
    do_clear(); pulse_wclk(); pulse_upd();
    shift_word(mk_word(t, 2'b00, 1'b0, 5'd0)); pulse_upd();
    shift_word(mk_word(t2, 2'b00, 1'b0, 5'd0));
    step_check(t, "R5 shift without update");
    pulse_upd();
    step_check(t2, "R5 after update");

    // control bits ignored
    shift_word(mk_word(32'h0000_7777, 2'b11, 1'b0, 5'd0)); pulse_upd();
    step_check(32'h0000_7777, "R10 control bits set");

    // power-down
    shift_word(mk_word(32'h0000_7777, 2'b10, 1'b1, 5'd9)); pulse_upd();
    check(phase == 0 && !sq, "R9 power-down outputs", 64'({sq, phase}), 64'd0);
    wait_n(7);
    check(phase == 0 && !sq, "R9 power-down stays low", 64'({sq, phase}), 64'd0);
    shift_word(mk_word(32'h0000_5555, 2'b00, 1'b0, 5'd0)); pulse_upd();
    step_check(32'h0000_5555, "R9 resume");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule